// File: doc/BRIEF.md
# Programmable YUV-to-RGB Color Matrix

This block converts a stream of 8-bit luma/chroma pixels for one overlay window into 8-bit red/green/blue. Each output channel is a weighted sum of Y, Cb and Cr plus a channel offset. The sum is rounded to the nearest integer and clamped to 0..255. Nine signed weights with ten fraction bits and three signed offsets with twelve fraction bits are held in eight 32-bit words. Software reads and writes these words through a simple word-indexed port. After reset the words hold a standard-definition limited-range conversion.

Software writes go to a staging copy. The staged set and the window enable move into the working set only when a frame-start strobe arrives. Software clears the enable for RGB buffers, and the pixels then pass through unchanged. The pixel path is a three-stage pipeline with a valid/ready handshake, and all three stages stall together.

Top module: `ycc_rgb_matrix`

## Requirements
- R1: Word index `reg_idx` selects byte offset 4*`reg_idx`. The weights are numbered 0..8 row-major, with rows R,G,B and columns Y,Cb,Cr. Word k (k=0..3) holds weight 2k in bits 15:0 and weight 2k+1 in bits 31:16. Word 4 holds weight 8 in bits 15:0. Words 5, 6 and 7 hold the R, G and B offsets.
- R2: After reset the words read 0x000004A8, 0x04A80662, 0x1CBF1E6F, 0x081204A8, 0x00000000, 0x00321168, 0x000877CF and 0x002EB127, in index order. The working enable is clear, so the block bypasses until the first frame start.
- R3: `reg_rdata` returns the last value written to the selected word. Bits 31:16 of word 4 always read zero.
- R4: Bits 12:0 of each weight field are a signed value with 10 fraction bits. Bits 21:0 of each offset word are a signed value with 12 fraction bits. With conversion enabled, channel c = floor((4*(w0*Y + w1*Cb + w2*Cr) + off + 2048) / 4096), clamped as in R5. Cb and Cr are taken as raw unsigned values.
- R5: A negative result gives 0, and a result above 255 gives 255.
- R6: With the working enable clear, the outputs copy the inputs: Y to `m_r`, Cb to `m_g`, Cr to `m_b`.
- R7: Register writes and `conv_en` change the output only for pixels accepted after a cycle with `frame_start` high.
- R8: With `m_ready` high, a pixel accepted at clock edge n appears on the outputs with `m_valid` after edge n+2. It is not visible earlier. Pixels accepted on consecutive edges leave in order on consecutive cycles.
- R9: While `m_valid` is high and `m_ready` is low, the outputs hold steady and `s_ready` is low. No pixel is lost or duplicated.
- R10: During and right after reset, `m_valid` is low and `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the staged word |
| reg_idx | input | 3 | Word index (byte offset / 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Staged word at `reg_idx` |
| frame_start | input | 1 | Moves staged words and enable into the working set |
| conv_en | input | 1 | Window enable, sampled at frame start |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted when high with `s_valid` |
| s_y | input | 8 | Luma (or R in bypass) |
| s_cb | input | 8 | Blue-difference chroma (or G) |
| s_cr | input | 8 | Red-difference chroma (or B) |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream accepts output |
| m_r | output | 8 | Red |
| m_g | output | 8 | Green |
| m_b | output | 8 | Blue |

## Verification
A wrong staged word shows on `reg_rdata` as soon as that index is selected. A wrong working weight or offset shows only on pixels accepted after the next frame start, three edges later, as a channel that differs from the bench's arithmetic model. A broken stall or valid chain shows within one cycle as changing output data under backpressure, as a missing or doubled beat, or as `m_valid` rising one edge early or late. Pixel choices near black, white and the clamp limits make rounding and sign-extension errors visible as off-by-one or wrapped values.

// File: rtl/ycc_rgb_matrix.sv
module ycc_rgb_matrix #(
  parameter int PIX_W     = 8,
  parameter int COEF_W    = 13,
  parameter int COEF_FRAC = 10,
  parameter int OFS_W     = 22,
  parameter int OFS_FRAC  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_idx,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             frame_start,
  input  logic             conv_en,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [PIX_W-1:0] s_y,
  input  logic [PIX_W-1:0] s_cb,
  input  logic [PIX_W-1:0] s_cr,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [PIX_W-1:0] m_r,
  output logic [PIX_W-1:0] m_g,
  output logic [PIX_W-1:0] m_b
);
  localparam int PROD_W = COEF_W + PIX_W + 1;
  localparam int SHIFT  = OFS_FRAC - COEF_FRAC;
  localparam int ACC_W  = PROD_W + SHIFT + 3;
  localparam int RES_W  = ACC_W - OFS_FRAC;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(2 ** (OFS_FRAC - 1));

  function automatic logic [31:0] dflt(input int i);
    case (i)
      0: return 32'h0000_04A8;
      1: return 32'h04A8_0662;
      2: return 32'h1CBF_1E6F;
      3: return 32'h0812_04A8;
      4: return 32'h0000_0000;
      5: return 32'h0032_1168;
      6: return 32'h0008_77CF;
      default: return 32'h002E_B127;
    endcase
  endfunction

  logic [31:0] stg [8];
  logic signed [COEF_W-1:0] cf_act [9];
  logic signed [OFS_W-1:0] ofs_act [3];
  logic en_act;

  assign reg_rdata = stg[reg_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) stg[i] <= dflt(i);
      for (int k = 0; k < 9; k++)
        cf_act[k] <= (k % 2 == 1) ? dflt(k / 2)[16 +: COEF_W] : dflt(k / 2)[0 +: COEF_W];
      for (int c = 0; c < 3; c++) ofs_act[c] <= dflt(5 + c)[OFS_W-1:0];
      en_act <= 1'b0;
    end else begin
      if (reg_wr) stg[reg_idx] <= (reg_idx == 3'd4) ? {16'h0, reg_wdata[15:0]} : reg_wdata;
      if (frame_start) begin
        for (int k = 0; k < 9; k++)
          cf_act[k] <= (k % 2 == 1) ? stg[k / 2][16 +: COEF_W] : stg[k / 2][0 +: COEF_W];
        for (int c = 0; c < 3; c++) ofs_act[c] <= stg[5 + c][OFS_W-1:0];
        en_act <= conv_en;
      end
    end
  end

  logic adv;
  assign adv     = !m_valid || m_ready;
  assign s_ready = adv;

  logic [PIX_W-1:0] pin [3];
  assign pin[0] = s_y;
  assign pin[1] = s_cb;
  assign pin[2] = s_cr;

  logic v1, v2, byp1, byp2;
  logic [PIX_W-1:0] raw1 [3];
  logic [PIX_W-1:0] raw2 [3];
  logic [PIX_W-1:0] out3 [3];
  logic signed [PROD_W-1:0] prod1 [9];
  logic signed [OFS_W-1:0]  ofs1 [3];
  logic signed [ACC_W-1:0]  acc2 [3];
  logic signed [RES_W-1:0]  res [3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      m_valid <= 1'b0;
    end else if (adv) begin
      v1 <= s_valid;
      v2 <= v1;
      m_valid <= v2;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      byp1 <= !en_act;
      for (int k = 0; k < 9; k++) prod1[k] <= cf_act[k] * $signed({1'b0, pin[k % 3]});
      for (int c = 0; c < 3; c++) begin
        raw1[c] <= pin[c];
        ofs1[c] <= ofs_act[c];
      end
      byp2 <= byp1;
      for (int c = 0; c < 3; c++) begin
        raw2[c] <= raw1[c];
        acc2[c] <= ((ACC_W'(prod1[3*c]) + ACC_W'(prod1[3*c+1]) + ACC_W'(prod1[3*c+2])) <<< SHIFT)
                   + ACC_W'(ofs1[c]) + HALF;
      end
      for (int c = 0; c < 3; c++) begin
        if (byp2)                        out3[c] <= raw2[c];
        else if (res[c][RES_W-1])        out3[c] <= '0;
        else if (|res[c][RES_W-2:PIX_W]) out3[c] <= '1;
        else                             out3[c] <= res[c][PIX_W-1:0];
      end
    end
  end

  always_comb
    for (int c = 0; c < 3; c++) res[c] = RES_W'(acc2[c] >>> OFS_FRAC);

  assign m_r = out3[0];
  assign m_g = out3[1];
  assign m_b = out3[2];
endmodule

// File: rtl/ycc_rgb_matrix_chk.sv
module ycc_rgb_matrix_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       reg_idx,
  input logic [31:0]      reg_rdata,
  input logic             s_ready,
  input logic             m_valid,
  input logic             m_ready,
  input logic [PIX_W-1:0] m_r,
  input logic [PIX_W-1:0] m_g,
  input logic [PIX_W-1:0] m_b
);
  a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_r) && $stable(m_g) && $stable(m_b));

  a_r9_stall_ready: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |-> !s_ready);

  a_r10_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !m_valid |-> s_ready);

  a_r10_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !m_valid);

  a_r3_word4_upper: assert property (@(posedge clk) disable iff (!rst_n)
    reg_idx == 3'd4 |-> reg_rdata[31:16] == 16'h0);
endmodule

bind ycc_rgb_matrix ycc_rgb_matrix_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_rdata(reg_rdata),
  .s_ready(s_ready), .m_valid(m_valid), .m_ready(m_ready),
  .m_r(m_r), .m_g(m_g), .m_b(m_b)
);

// File: tb/ycc_rgb_matrix_bench.sv
module ycc_rgb_matrix_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic frame_start = 1'b0, conv_en = 1'b0;
  logic s_valid = 1'b0, s_ready;
  logic [7:0] s_y = '0, s_cb = '0, s_cr = '0;
  logic m_valid, m_ready = 1'b1;
  logic [7:0] m_r, m_g, m_b;

  always #5 clk = ~clk;

  ycc_rgb_matrix u_ycc_rgb_matrix (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .conv_en(conv_en), .s_valid(s_valid), .s_ready(s_ready), .s_y(s_y),
    .s_cb(s_cb), .s_cr(s_cr), .m_valid(m_valid), .m_ready(m_ready),
    .m_r(m_r), .m_g(m_g), .m_b(m_b)
  );

  int n_chk = 0, n_fail = 0;
  int st [8];
  int aw [8];
  bit en_a = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dflt(input int i);
    case (i)
      0: return 'h000004A8; 1: return 'h04A80662; 2: return 'h1CBF1E6F;
      3: return 'h081204A8; 4: return 0;          5: return 'h00321168;
      6: return 'h000877CF; default: return 'h002EB127;
    endcase
  endfunction

  function automatic int sxt(input int v, input int w);
    int t = v << (32 - w);
    return t >>> (32 - w);
  endfunction

  function automatic int chan(input int c, input int y, input int cb, input int cr);
    int w [3];
    int a;
    for (int j = 0; j < 3; j++) begin
      int k = 3 * c + j;
      int f = (k % 2 == 1) ? ((aw[k / 2] >> 16) & 'hFFFF) : (aw[k / 2] & 'hFFFF);
      w[j] = sxt(f & 'h1FFF, 13);
    end
    a = 4 * (w[0] * y + w[1] * cb + w[2] * cr) + sxt(aw[5 + c] & 'h3FFFFF, 22) + 2048;
    a = a >>> 12;
    if (a < 0) a = 0;
    if (a > 255) a = 255;
    return a;
  endfunction

  function automatic int expect_rgb(input int y, input int cb, input int cr);
    if (!en_a) return (y << 16) | (cb << 8) | cr;
    return (chan(0, y, cb, cr) << 16) | (chan(1, y, cb, cr) << 8) | chan(2, y, cb, cr);
  endfunction

  task automatic wr(input int idx, input int data);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = 3'(idx); reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
    st[idx] = (idx == 4) ? (data & 'hFFFF) : data;
  endtask

  task automatic rd(input int idx, input string req);
    @(negedge clk);
    reg_idx = 3'(idx);
    #1;
    chk(reg_rdata == st[idx], req, reg_rdata, st[idx]);
  endtask

  task automatic frame(input bit en);
    @(negedge clk);
    frame_start = 1'b1; conv_en = en;
    @(negedge clk);
    frame_start = 1'b0;
    aw = st; en_a = en;
  endtask

  task automatic pix(input int y, input int cb, input int cr, input string req);
    int e = expect_rgb(y, cb, cr);
    @(negedge clk);
    s_valid = 1'b1; s_y = 8'(y); s_cb = 8'(cb); s_cr = 8'(cr);
    chk(s_ready, "R10 ready", s_ready, 1);
    @(negedge clk);
    s_valid = 1'b0;
    @(negedge clk);
    chk(!m_valid, "R8 early", m_valid, 0);
    @(negedge clk);
    chk(m_valid && {m_r, m_g, m_b} == 24'(e), req, {m_valid, m_r, m_g, m_b}, {1'b1, 24'(e)});
  endtask

  task automatic t_reset;
    chk(!m_valid && s_ready, "R10 reset", {m_valid, s_ready}, 2'b01);
    for (int i = 0; i < 8; i++) rd(i, "R2 default word");
  endtask

  task automatic t_default;
    frame(1);
    pix(16, 128, 128, "R4 black");
    pix(235, 128, 128, "R4 white");
    pix(81, 90, 240, "R4 red");
    pix(145, 54, 34, "R4 green");
    pix(41, 240, 110, "R4 blue");
  endtask

  task automatic t_clamp;
    pix(255, 128, 255, "R5 high");
    pix(0, 128, 0, "R5 low");
    pix(255, 255, 255, "R5 mixed");
  endtask

  task automatic t_bypass;
    frame(0);
    pix(12, 200, 77, "R6 bypass");
    chk({m_r, m_g, m_b} == 24'h0CC84D, "R6 literal", {m_r, m_g, m_b}, 24'h0CC84D);
    frame(1);
  endtask

  task automatic t_shadow;
    wr(0, 'h00000400); wr(1, 0); wr(2, 'h00000400); wr(3, 0);
    wr(4, 'hABCD0400); wr(5, 0); wr(6, 'h00001000); wr(7, 'hFFFFF000);
    rd(4, "R3 word4 upper zero");
    rd(7, "R3 offset readback");
    rd(2, "R1 packing readback");
    pix(100, 50, 200, "R7 old set until frame start");
    frame(1);
    pix(100, 50, 200, "R7 new set");
    chk({m_r, m_g, m_b} == {8'd100, 8'd51, 8'd199}, "R1 field positions",
        {m_r, m_g, m_b}, {8'd100, 8'd51, 8'd199});
    pix(0, 0, 0, "R5 negative offset");
  endtask

  task automatic t_stream;
    int e [3];
    e[0] = expect_rgb(1, 2, 3); e[1] = expect_rgb(40, 50, 60); e[2] = expect_rgb(200, 210, 220);
    @(negedge clk); s_valid = 1; s_y = 1;   s_cb = 2;   s_cr = 3;
    @(negedge clk); s_y = 40;  s_cb = 50;  s_cr = 60;
    @(negedge clk); s_y = 200; s_cb = 210; s_cr = 220;
    @(negedge clk); s_valid = 0;
    for (int i = 0; i < 3; i++) begin
      chk(m_valid && {m_r, m_g, m_b} == 24'(e[i]), "R8 order", {m_valid, m_r, m_g, m_b}, {1'b1, 24'(e[i])});
      @(negedge clk);
    end
    chk(!m_valid, "R8 no extra beat", m_valid, 0);
  endtask

  task automatic t_stall;
    int ea = expect_rgb(10, 20, 30);
    int eb = expect_rgb(77, 88, 99);
    @(negedge clk); m_ready = 0; s_valid = 1; s_y = 10; s_cb = 20; s_cr = 30;
    @(negedge clk); s_valid = 0;
    @(negedge clk);
    @(negedge clk);
    s_valid = 1; s_y = 77; s_cb = 88; s_cr = 99;
    for (int i = 0; i < 3; i++) begin
      chk(m_valid && {m_r, m_g, m_b} == 24'(ea), "R9 hold", {m_valid, m_r, m_g, m_b}, {1'b1, 24'(ea)});
      chk(!s_ready, "R9 stall ready", s_ready, 0);
      @(negedge clk);
    end
    m_ready = 1;
    @(negedge clk); s_valid = 0;
    chk(!m_valid, "R9 single retire", m_valid, 0);
    @(negedge clk);
    @(negedge clk);
    chk(m_valid && {m_r, m_g, m_b} == 24'(eb), "R9 no loss", {m_valid, m_r, m_g, m_b}, {1'b1, 24'(eb)});
    @(negedge clk);
    chk(!m_valid, "R9 no duplicate", m_valid, 0);
  endtask

  initial begin
    #2_000_000;
    chk(0, "R8 watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      st[i] = dflt(i);
      aw[i] = dflt(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_default;
    t_clamp;
    t_bypass;
    t_stream;
    t_shadow;
    t_stall;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule